// File: doc/BRIEF.md
# Framing Error Event Counter

This block is the performance-monitoring tally that sits beside a T1/E1 receive framer. Every clock it takes a set of single-cycle event strobes from the framer, along with the loss-of-sync and alignment-search status flags. Three configuration inputs decide which strobe is counted and whether loss of sync stops the count: the line type (T1 or E1), the T1 superframe format (D4 or ESF) and a count-type select. In T1 the select chooses between counting out-of-sync multiframes and counting framing-bit errors. The D4/ESF format decides which framing-bit pattern supplies those errors. E1 always counts FAS word errors.

The live count is 16 bits wide. A one-second latch strobe moves it into a holding register, which software reads as a high byte and a low byte. The same strobe restarts the live count. Between strobes the readable bytes stay fixed, so software always reads one coherent snapshot of the last interval. A one-second E1 interval holds at most 4000 FAS errors, so under normal latching the count never comes near its ceiling. The live count still stops at all ones rather than wrapping.

Top module: `fec_counter`

## Requirements
- R1: A synchronous active-high `rst` clears the live count and the holding register. `cnt_hi` and `cnt_lo` read 0 after reset, and a latch taken straight after reset reports 0.
- R2: With `line_e1`=0 and `cnt_fbit`=0, each cycle with `mos_stb`=1 adds one. This holds while `rx_los`=1. `ft_err_stb`, `fps_err_stb` and `fas_err_stb` have no effect.
- R3: With `line_e1`=0, `cnt_fbit`=1 and `fmt_esf`=0 (D4), only `ft_err_stb` is counted. `fps_err_stb` and `mos_stb` have no effect.
- R4: With `line_e1`=0, `cnt_fbit`=1 and `fmt_esf`=1 (ESF), only `fps_err_stb` is counted. `ft_err_stb` and `mos_stb` have no effect.
- R5: In T1 with `cnt_fbit`=1, no event is counted while `rx_los`=1.
- R6: With `line_e1`=1, each cycle with `fas_err_stb`=1 adds one, unless `rx_los`=1. The other strobes have no effect.
- R7: With `line_e1`=1, `fas_err_stb` is ignored while `search_act`=1.
- R8: On a clock with `sec_latch`=1, the holding register takes the live count as it stood before that clock. The live count restarts at 0, or at 1 if an event is counted in the same clock. `cnt_hi` is bits 15:8 and `cnt_lo` is bits 7:0, both valid one clock after the latch.
- R9: The live count stops at 16'hFFFF and does not wrap.
- R10: `cnt_hi` and `cnt_lo` change only on a clock with `sec_latch`=1 or in reset.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_e1 | input | 1 | 1 selects E1 and 0 selects T1 |
| fmt_esf | input | 1 | T1 format: 1 selects ESF and 0 selects D4 |
| cnt_fbit | input | 1 | T1 count select: 1 counts framing-bit errors and 0 counts out-of-sync multiframes |
| mos_stb | input | 1 | Strobe: one receive multiframe spent out of sync |
| ft_err_stb | input | 1 | Strobe: Ft pattern bit error |
| fps_err_stb | input | 1 | Strobe: FPS pattern bit error |
| fas_err_stb | input | 1 | Strobe: FAS word error in time slot 0 |
| rx_los | input | 1 | Receive loss-of-sync flag |
| search_act | input | 1 | Framer searching for FAS, CAS or CRC4 alignment |
| sec_latch | input | 1 | One-second latch strobe |
| cnt_hi | output | 8 | Latched count, most significant byte |
| cnt_lo | output | 8 | Latched count, least significant byte |

## Verification
The live count is a register, so an event sampled at one rising edge is in the live count after that edge. It reaches `cnt_hi`/`cnt_lo` only through the next latch, and appears one edge after the edge that samples `sec_latch`. The bench drives every input just after a falling edge. Its driver predicts the latched value at the moment it raises `sec_latch`. A monitor sees the latch at the rising edge, waits for the following falling edge, and then compares the byte outputs with the prediction. Stability checks between latches also sample at falling edges, where no register is changing.

// File: rtl/fec_pkg.sv
package fec_pkg;

  typedef enum logic [1:0] {
    SRC_MOS = 2'd0,
    SRC_FT  = 2'd1,
    SRC_FPS = 2'd2,
    SRC_FAS = 2'd3
  } evt_src_e;

  function automatic evt_src_e pick_source(input logic e1, input logic esf,
                                           input logic fbit);
    evt_src_e s;
    if (e1)          s = SRC_FAS;
    else if (!fbit)  s = SRC_MOS;
    else if (esf)    s = SRC_FPS;
    else             s = SRC_FT;
    return s;
  endfunction

endpackage

// File: rtl/fec_event_sel.sv
module fec_event_sel
  import fec_pkg::*;
(
  input  logic line_e1,
  input  logic fmt_esf,
  input  logic cnt_fbit,
  input  logic mos_stb,
  input  logic ft_err_stb,
  input  logic fps_err_stb,
  input  logic fas_err_stb,
  input  logic rx_los,
  input  logic search_act,
  output logic evt
);

  evt_src_e src;
  logic     raw;
  logic     gate_ok;

  always_comb begin
    src = pick_source(line_e1, fmt_esf, cnt_fbit);
    unique case (src)
      SRC_MOS: raw = mos_stb;
      SRC_FT:  raw = ft_err_stb;
      SRC_FPS: raw = fps_err_stb;
      SRC_FAS: raw = fas_err_stb;
      default: raw = 1'b0;
    endcase
  end

  // Out-of-sync multiframe counting runs through loss of sync; the others stop.
  always_comb begin
    unique case (src)
      SRC_MOS: gate_ok = 1'b1;
      SRC_FT,
      SRC_FPS: gate_ok = !rx_los;
      SRC_FAS: gate_ok = !rx_los && !search_act;
      default: gate_ok = 1'b0;
    endcase
  end

  assign evt = raw && gate_ok;

endmodule

// File: rtl/fec_live_count.sv
module fec_live_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt,
  input  logic             restart,
  output logic [CNT_W-1:0] live
);

  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)
      live <= '0;
    else if (restart)
      live <= evt ? ONE : '0;
    else if (evt && live != MAXV)
      live <= live + ONE;
  end

  p_sat_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (live == MAXV && !restart) |=> live == MAXV);

  p_step_one_r2: assert property (@(posedge clk) disable iff (rst)
    !restart |=> (live == $past(live)) || (live == $past(live) + ONE));

  p_restart_r8: assert property (@(posedge clk) disable iff (rst)
    restart |=> live <= ONE);

endmodule

// File: rtl/fec_hold_regs.sv
module fec_hold_regs #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CNT_W-1:0]  din,
  output logic [BYTE_W-1:0] hi,
  output logic [BYTE_W-1:0] lo
);

  localparam int NBYTES = CNT_W / BYTE_W;

  logic [BYTE_W-1:0] bytes_q [NBYTES];

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)
        bytes_q[g] <= '0;
      else if (load)
        bytes_q[g] <= din[g*BYTE_W +: BYTE_W];
    end
  end

  assign lo = bytes_q[0];
  assign hi = bytes_q[NBYTES-1];

  p_stable_r10: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(hi) && $stable(lo)));

endmodule

// File: rtl/fec_counter.sv
module fec_counter #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_e1,
  input  logic              fmt_esf,
  input  logic              cnt_fbit,
  input  logic              mos_stb,
  input  logic              ft_err_stb,
  input  logic              fps_err_stb,
  input  logic              fas_err_stb,
  input  logic              rx_los,
  input  logic              search_act,
  input  logic              sec_latch,
  output logic [BYTE_W-1:0] cnt_hi,
  output logic [BYTE_W-1:0] cnt_lo
);

  logic             evt;
  logic [CNT_W-1:0] live;

  fec_event_sel u_sel (
    .line_e1     (line_e1),
    .fmt_esf     (fmt_esf),
    .cnt_fbit    (cnt_fbit),
    .mos_stb     (mos_stb),
    .ft_err_stb  (ft_err_stb),
    .fps_err_stb (fps_err_stb),
    .fas_err_stb (fas_err_stb),
    .rx_los      (rx_los),
    .search_act  (search_act),
    .evt         (evt)
  );

  fec_live_count #(.CNT_W(CNT_W)) u_live (
    .clk     (clk),
    .rst     (rst),
    .evt     (evt),
    .restart (sec_latch),
    .live    (live)
  );

  fec_hold_regs #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_hold (
    .clk  (clk),
    .rst  (rst),
    .load (sec_latch),
    .din  (live),
    .hi   (cnt_hi),
    .lo   (cnt_lo)
  );

  p_latch_copy_r8: assert property (@(posedge clk) disable iff (rst)
    sec_latch |=> {cnt_hi, cnt_lo} == $past(live));

  p_fbit_los_r5: assert property (@(posedge clk) disable iff (rst)
    (!line_e1 && cnt_fbit && rx_los && !sec_latch) |=> $stable(live));

  p_e1_los_r6: assert property (@(posedge clk) disable iff (rst)
    (line_e1 && rx_los && !sec_latch) |=> $stable(live));

  p_e1_search_r7: assert property (@(posedge clk) disable iff (rst)
    (line_e1 && search_act && !sec_latch) |=> $stable(live));

endmodule

// File: tb/tb_fec_counter.sv
module tb_fec_counter;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_e1 = 0, fmt_esf = 0, cnt_fbit = 0;
  logic mos_stb = 0, ft_err_stb = 0, fps_err_stb = 0, fas_err_stb = 0;
  logic rx_los = 0, search_act = 0, sec_latch = 0;
  logic [7:0] cnt_hi, cnt_lo;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] exp_q[$];
  string       req_q[$];
  logic [15:0] mcount = 0;
  logic [15:0] last_latched = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fec_counter dut (
    .clk(clk), .rst(rst), .line_e1(line_e1), .fmt_esf(fmt_esf),
    .cnt_fbit(cnt_fbit), .mos_stb(mos_stb), .ft_err_stb(ft_err_stb),
    .fps_err_stb(fps_err_stb), .fas_err_stb(fas_err_stb), .rx_los(rx_los),
    .search_act(search_act), .sec_latch(sec_latch),
    .cnt_hi(cnt_hi), .cnt_lo(cnt_lo)
  );

  task automatic check(input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit counted(input logic mos, input logic ft,
                                 input logic fps, input logic fas,
                                 input logic los, input logic srch);
    if (line_e1) return fas && !los && !srch;
    if (!cnt_fbit) return mos;
    if (los) return 0;
    return fmt_esf ? fps : ft;
  endfunction

  // Driver: one clock of stimulus, model updated, expectation queued on latch.
  task automatic step(input logic mos, input logic ft, input logic fps,
                      input logic fas, input logic los, input logic srch,
                      input logic lat, input string req);
    bit c;
    mos_stb = mos; ft_err_stb = ft; fps_err_stb = fps; fas_err_stb = fas;
    rx_los = los; search_act = srch; sec_latch = lat;
    c = counted(mos, ft, fps, fas, los, srch);
    if (lat) begin
      exp_q.push_back(mcount);
      req_q.push_back(req);
      mcount = c ? 16'd1 : 16'd0;
    end else if (c && mcount != 16'hFFFF) begin
      mcount = mcount + 16'd1;
    end
    @(negedge clk);
    mos_stb = 0; ft_err_stb = 0; fps_err_stb = 0; fas_err_stb = 0;
    sec_latch = 0;
  endtask

  task automatic latch(input string req);
    step(0, 0, 0, 0, 0, 0, 1, req);
  endtask

  task automatic set_mode(input logic e1, input logic esf, input logic fb);
    line_e1 = e1; fmt_esf = esf; cnt_fbit = fb;
    latch("R8 clear");
  endtask

  // Monitor: compare outputs one edge after each latch.
  initial begin
    forever begin
      @(posedge clk);
      if (sec_latch && !rst) begin
        @(negedge clk);
        if (exp_q.size() > 0) begin
          last_latched = exp_q.pop_front();
          check(req_q.pop_front(), {cnt_hi, cnt_lo}, last_latched);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1 reset outputs", {cnt_hi, cnt_lo}, 16'h0000);
    latch("R1 live after reset");

    // R2: T1 out-of-sync multiframe mode, counts through loss of sync
    set_mode(0, 0, 0);
    for (int i = 0; i < 5; i++) step(1, 1, 1, 1, 0, 0, 0, "");
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 1, 0, 0, "");
    step(0, 1, 1, 1, 0, 1, 0, "");
    latch("R2 T1 MOS count");

    // R10: outputs hold between latches
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0, 0, "");
    check("R10 stable between latches", {cnt_hi, cnt_lo}, last_latched);
    latch("R2 T1 MOS second interval");

    // R3: D4 Ft errors
    set_mode(0, 0, 1);
    for (int i = 0; i < 7; i++) step(0, 1, 0, 0, 0, 0, 0, "");
    for (int i = 0; i < 3; i++) step(1, 0, 1, 1, 0, 0, 0, "");
    latch("R3 D4 Ft count");

    // R4: ESF FPS errors
    set_mode(0, 1, 1);
    for (int i = 0; i < 6; i++) step(0, 0, 1, 0, 0, 0, 0, "");
    for (int i = 0; i < 3; i++) step(1, 1, 0, 1, 0, 0, 0, "");
    latch("R4 ESF FPS count");

    // R5: F-bit mode inhibited by loss of sync
    for (int i = 0; i < 2; i++) step(0, 0, 1, 0, 0, 0, 0, "");
    for (int i = 0; i < 5; i++) step(0, 1, 1, 0, 1, 0, 0, "");
    latch("R5 ESF inhibited by LOS");
    set_mode(0, 0, 1);
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 1, 0, 0, "");
    latch("R5 D4 inhibited by LOS");

    // R6: E1 FAS errors, inhibited by loss of sync
    set_mode(1, 0, 0);
    for (int i = 0; i < 9; i++) step(0, 0, 0, 1, 0, 0, 0, "");
    for (int i = 0; i < 3; i++) step(1, 1, 1, 0, 0, 0, 0, "");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 1, 0, 0, "");
    latch("R6 E1 FAS count");

    // R7: search in progress masks FAS errors
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, 0, 0, "");
    for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 0, 1, 0, "");
    latch("R7 E1 search mask");

    // R8: event in the latch cycle starts next interval at one
    for (int i = 0; i < 2; i++) step(0, 0, 0, 1, 0, 0, 0, "");
    step(0, 0, 0, 1, 0, 0, 1, "R8 latch with event");
    step(0, 0, 0, 1, 0, 0, 0, "");
    latch("R8 restart at one");

    // R8: byte split across a 256 boundary
    for (int i = 0; i < 300; i++) step(0, 0, 0, 1, 0, 0, 0, "");
    latch("R8 high byte split");

    // R9: saturation
    for (int i = 0; i < 65540; i++) step(0, 0, 0, 1, 0, 0, 0, "");
    latch("R9 saturate at FFFF");
    latch("R8 cleared after saturation");

    // R1: reset mid-interval clears outputs and live count
    for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 0, 0, 0, "");
    rst = 1;
    @(negedge clk);
    rst = 0;
    mcount = 0;
    check("R1 reset mid-run outputs", {cnt_hi, cnt_lo}, 16'h0000);
    latch("R1 live cleared by reset");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule